// File: doc/BRIEF.md
# Operand Effective Address Generator

This unit forms the 24-bit memory address of an instruction operand for a 16-bit processor. The caller presents an addressing-mode code, a pointer selector, an optional displacement, an operand size, the current instruction address with its length offset, the eight 16-bit general word registers and four 8-bit bank registers. One clock after a start strobe, the unit presents the operand address together with a valid pulse and an error flag. The low 16 bits come from a wrapping 16-bit sum. The top byte comes from a bank register. Which bank is used depends on the mode and on which pointer takes part.

For the post-increment mode, the unit also holds the advanced pointer value. It drives the register-file write port for that pointer during the cycle in which the operand access completes, so the register file takes the write on that cycle's closing edge. If the instruction writes its own data into that same register in that cycle, the instruction data is put on the write port in place of the advanced pointer.

Top module: `oaddr_unit`

## Requirements
- R1: Pointer-based modes take the top address byte from the pointer index: pointers 0, 1, 4 and 5 use the data bank, pointers 2 and 6 use the additional bank, and pointers 3 and 7 use the stack bank.
- R2: Mode code 0 (plain indirect) with pointer 0..3 gives the address {bank, pointer}.
- R3: Mode code 1 (post-increment) with pointer 0..3 gives the address {bank, pointer value at start}. In the cycle acc_done is high, wb_en is high, wb_idx is the pointer and wb_val is the start value plus the step. The size code sets the step: 0 is 1 (byte), 1 is 2 (word), 2 is 4 (long). With no post-increment pending, acc_done leaves wb_en low.
- R4: When wr_en is high and wr_idx equals the pending pointer in the acc_done cycle, wb_val equals wr_data.
- R5: After a post-increment writeback, the next address formed from that pointer uses the written value.
- R6: Mode code 2 adds disp[7:0], sign-extended, to any of pointers 0..7.
- R7: Mode code 3 adds the full 16-bit disp to pointer 0..3. Pointers 4..7 in this mode give an error.
- R8: Mode code 4 with selector 0 or 1 adds pointer 7 to pointer 0 or pointer 1 and uses the data bank. Selectors 2..7 give an error.
- R9: Mode code 5 gives {program bank, pc_addr + pc_ofs + disp} and ignores sel.
- R10: Every 16-bit sum wraps modulo 2^16 and never changes the bank byte.
- R11: Mode codes 6 and 7, pointers 4..7 in modes 0 and 1, and size code 3 in mode 1 all raise ea_err with ea equal to 0, and no writeback is scheduled.
- R12: ea_vld pulses exactly one cycle after start, and ea and ea_err hold their values until the next start. After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begin an address computation with the current inputs |
| mode | input | 3 | Addressing-mode code |
| sel | input | 3 | Pointer selector |
| disp | input | 16 | Displacement (low byte used by mode 2) |
| opsize | input | 2 | Operand size code for post-increment |
| pc_addr | input | 16 | Current instruction address |
| pc_ofs | input | 4 | Instruction-length offset for PC-relative mode |
| gpr_flat | input | 128 | Eight word registers, register i at bits 16i+15:16i |
| bank_dat | input | 8 | Data bank byte |
| bank_add | input | 8 | Additional bank byte |
| bank_stk | input | 8 | Stack bank byte |
| bank_prg | input | 8 | Program bank byte |
| acc_done | input | 1 | Operand access completes at the end of this cycle |
| wr_en | input | 1 | Instruction writes a word register in this cycle |
| wr_idx | input | 3 | Register written by the instruction |
| wr_data | input | 16 | Data written by the instruction |
| ea_vld | output | 1 | Address valid pulse |
| ea | output | 24 | Operand address |
| ea_err | output | 1 | Illegal mode, selector or size |
| wb_en | output | 1 | Pointer write port enable |
| wb_idx | output | 3 | Pointer write port index |
| wb_val | output | 16 | Pointer write port data |

## Verification
The bench runs every mode with every selector and several displacements, including 0x80 in the low byte and sums that cross 0xFFFF. A design that zero-extends the byte displacement, or carries into the bank byte, gives addresses that differ from the arithmetic model. For post-increment it runs every size code and alternates between conflicting and non-conflicting instruction writes. A wrong step, a writeback outside the completion cycle, or advanced-pointer data that wins over the instruction write would show up at the write port, or in the address read back through the same pointer afterwards. Illegal selectors, sizes and modes must raise the error flag, force the address to 0 and leave the write port idle.

// File: rtl/oaddr_pkg.sv
package oaddr_pkg;
  localparam int MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    AM_IND   = 3'd0,
    AM_PINC  = 3'd1,
    AM_D8    = 3'd2,
    AM_D16   = 3'd3,
    AM_BIDX  = 3'd4,
    AM_PCREL = 3'd5,
    AM_RSV6  = 3'd6,
    AM_RSV7  = 3'd7
  } am_e;

  typedef enum logic [1:0] {
    BK_DAT = 2'd0,
    BK_ADD = 2'd1,
    BK_STK = 2'd2,
    BK_PRG = 2'd3
  } bank_e;
endpackage

// File: rtl/oaddr_bank_sel.sv
module oaddr_bank_sel
  import oaddr_pkg::*;
(
  input  am_e         mode_i,
  input  logic [1:0]  sel_lo_i,
  output bank_e       bank_o
);
  always_comb begin
    unique case (mode_i)
      AM_PCREL: bank_o = BK_PRG;
      AM_BIDX:  bank_o = BK_DAT;
      default: begin
        unique case (sel_lo_i)
          2'd2:    bank_o = BK_ADD;
          2'd3:    bank_o = BK_STK;
          default: bank_o = BK_DAT;
        endcase
      end
    endcase
  end
endmodule

// File: rtl/oaddr_adder.sv
module oaddr_adder #(
  parameter int DW = 16
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic [DW-1:0] c_i,
  output logic [DW-1:0] sum_o
);
  always_comb sum_o = a_i + b_i + c_i;
endmodule

// File: rtl/oaddr_wb_mux.sv
module oaddr_wb_mux #(
  parameter int DW   = 16,
  parameter int SELW = 3
) (
  input  logic            pend_i,
  input  logic            done_i,
  input  logic [SELW-1:0] ptr_idx_i,
  input  logic [DW-1:0]   ptr_nxt_i,
  input  logic            wr_en_i,
  input  logic [SELW-1:0] wr_idx_i,
  input  logic [DW-1:0]   wr_data_i,
  output logic            wb_en_o,
  output logic [SELW-1:0] wb_idx_o,
  output logic [DW-1:0]   wb_val_o
);
  logic clash;

  always_comb begin
    clash    = wr_en_i && (wr_idx_i == ptr_idx_i);
    wb_en_o  = pend_i && done_i;
    wb_idx_o = ptr_idx_i;
    wb_val_o = clash ? wr_data_i : ptr_nxt_i;
  end
endmodule

// File: rtl/oaddr_unit.sv
module oaddr_unit
  import oaddr_pkg::*;
#(
  parameter int DW   = 16,
  parameter int BW   = 8,
  parameter int NREG = 8,
  parameter int OFSW = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [MODE_W-1:0]       mode,
  input  logic [$clog2(NREG)-1:0] sel,
  input  logic [DW-1:0]           disp,
  input  logic [1:0]              opsize,
  input  logic [DW-1:0]           pc_addr,
  input  logic [OFSW-1:0]         pc_ofs,
  input  logic [NREG*DW-1:0]      gpr_flat,
  input  logic [BW-1:0]           bank_dat,
  input  logic [BW-1:0]           bank_add,
  input  logic [BW-1:0]           bank_stk,
  input  logic [BW-1:0]           bank_prg,
  input  logic                    acc_done,
  input  logic                    wr_en,
  input  logic [$clog2(NREG)-1:0] wr_idx,
  input  logic [DW-1:0]           wr_data,
  output logic                    ea_vld,
  output logic [DW+BW-1:0]        ea,
  output logic                    ea_err,
  output logic                    wb_en,
  output logic [$clog2(NREG)-1:0] wb_idx,
  output logic [DW-1:0]           wb_val
);
  localparam int SELW = $clog2(NREG);
  localparam int AW   = DW + BW;
  localparam int NLOW = 4;
  localparam logic [SELW-1:0] SEL_LOW  = SELW'(NLOW);
  localparam logic [SELW-1:0] SEL_BMAX = SELW'(1);
  localparam logic [SELW-1:0] SEL_IDX  = SELW'(NREG-1);

  // reset: asynchronous assertion, synchronous release
  logic [1:0] rsync_q;
  logic       rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_i = rsync_q[1];

  // register file view
  logic [DW-1:0] gpr [NREG];
  for (genvar gi = 0; gi < NREG; gi++) begin : g_unpack
    assign gpr[gi] = gpr_flat[gi*DW +: DW];
  end

  am_e           am;
  bank_e         bk;
  logic [BW-1:0] bank_byte;
  logic [DW-1:0] op_a, op_b, op_c, sum;
  logic          err_d;
  logic [AW-1:0] ea_d;
  logic [DW-1:0] ptr_nxt_d;

  assign am = am_e'(mode);

  oaddr_bank_sel u_bank (
    .mode_i   (am),
    .sel_lo_i (sel[1:0]),
    .bank_o   (bk)
  );

  oaddr_adder #(.DW(DW)) u_add (
    .a_i   (op_a),
    .b_i   (op_b),
    .c_i   (op_c),
    .sum_o (sum)
  );

  always_comb begin
    unique case (bk)
      BK_ADD:  bank_byte = bank_add;
      BK_STK:  bank_byte = bank_stk;
      BK_PRG:  bank_byte = bank_prg;
      default: bank_byte = bank_dat;
    endcase
  end

  always_comb begin
    op_a  = gpr[sel];
    op_b  = '0;
    op_c  = '0;
    err_d = 1'b0;
    unique case (am)
      AM_IND:   err_d = (sel >= SEL_LOW);
      AM_PINC:  err_d = (sel >= SEL_LOW) || (opsize == 2'd3);
      AM_D8:    op_b  = {{(DW-8){disp[7]}}, disp[7:0]};
      AM_D16: begin
        op_b  = disp;
        err_d = (sel >= SEL_LOW);
      end
      AM_BIDX: begin
        op_b  = gpr[SEL_IDX];
        err_d = (sel > SEL_BMAX);
      end
      AM_PCREL: begin
        op_a = pc_addr;
        op_b = disp;
        op_c = DW'(pc_ofs);
      end
      default:  err_d = 1'b1;
    endcase
    ea_d      = err_d ? '0 : {bank_byte, sum};
    ptr_nxt_d = gpr[sel] + (DW'(1) << opsize);
  end

  // next state
  logic            vld_q, err_q, pend_q;
  logic [AW-1:0]   ea_q;
  logic [SELW-1:0] pidx_q;
  logic [DW-1:0]   pnxt_q;
  logic            vld_n, err_n, pend_n;
  logic [AW-1:0]   ea_n;
  logic [SELW-1:0] pidx_n;
  logic [DW-1:0]   pnxt_n;

  always_comb begin
    vld_n  = start;
    ea_n   = ea_q;
    err_n  = err_q;
    pend_n = pend_q && !acc_done;
    pidx_n = pidx_q;
    pnxt_n = pnxt_q;
    if (start) begin
      ea_n   = ea_d;
      err_n  = err_d;
      pend_n = (am == AM_PINC) && !err_d;
      pidx_n = sel;
      pnxt_n = ptr_nxt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      vld_q  <= 1'b0;
      ea_q   <= '0;
      err_q  <= 1'b0;
      pend_q <= 1'b0;
      pidx_q <= '0;
      pnxt_q <= '0;
    end else begin
      vld_q  <= vld_n;
      ea_q   <= ea_n;
      err_q  <= err_n;
      pend_q <= pend_n;
      pidx_q <= pidx_n;
      pnxt_q <= pnxt_n;
    end
  end

  oaddr_wb_mux #(.DW(DW), .SELW(SELW)) u_wb (
    .pend_i    (pend_q),
    .done_i    (acc_done),
    .ptr_idx_i (pidx_q),
    .ptr_nxt_i (pnxt_q),
    .wr_en_i   (wr_en),
    .wr_idx_i  (wr_idx),
    .wr_data_i (wr_data),
    .wb_en_o   (wb_en),
    .wb_idx_o  (wb_idx),
    .wb_val_o  (wb_val)
  );

  assign ea_vld = vld_q;
  assign ea     = ea_q;
  assign ea_err = err_q;
endmodule

// File: rtl/oaddr_chk.sv
module oaddr_chk #(
  parameter int DW   = 16,
  parameter int BW   = 8,
  parameter int NREG = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    start,
  input logic [2:0]              mode,
  input logic [$clog2(NREG)-1:0] sel,
  input logic [NREG*DW-1:0]      gpr_flat,
  input logic [BW-1:0]           bank_dat,
  input logic [BW-1:0]           bank_prg,
  input logic                    acc_done,
  input logic                    wr_en,
  input logic [$clog2(NREG)-1:0] wr_idx,
  input logic [DW-1:0]           wr_data,
  input logic                    ea_vld,
  input logic [DW+BW-1:0]        ea,
  input logic                    ea_err,
  input logic                    wb_en,
  input logic [$clog2(NREG)-1:0] wb_idx,
  input logic [DW-1:0]           wb_val
);
  assert_vld_next_R12: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> ea_vld);

  assert_ind_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && mode == 3'd0 && sel < 4) |=>
      ea[DW-1:0] == $past(gpr_flat[int'(sel)*DW +: DW]));

  assert_wb_on_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> acc_done);

  assert_clash_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_en && wr_en && wr_idx == wb_idx) |-> wb_val == wr_data);

  assert_d16_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (start && mode == 3'd3 && sel >= 4) |=> (ea_err && ea == '0));

  assert_bidx_bank_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && mode == 3'd4 && sel < 2) |=> ea[DW+BW-1:DW] == $past(bank_dat));

  assert_pc_bank_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (start && mode == 3'd5) |=> ea[DW+BW-1:DW] == $past(bank_prg));

  assert_bad_mode_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (start && mode[2:1] == 2'b11) |=> ea_err);
endmodule

bind oaddr_unit oaddr_chk #(.DW(DW), .BW(BW), .NREG(NREG)) u_oaddr_chk (
  .clk      (clk),
  .rst_n    (rst_i),
  .start    (start),
  .mode     (mode),
  .sel      (sel),
  .gpr_flat (gpr_flat),
  .bank_dat (bank_dat),
  .bank_prg (bank_prg),
  .acc_done (acc_done),
  .wr_en    (wr_en),
  .wr_idx   (wr_idx),
  .wr_data  (wr_data),
  .ea_vld   (ea_vld),
  .ea       (ea),
  .ea_err   (ea_err),
  .wb_en    (wb_en),
  .wb_idx   (wb_idx),
  .wb_val   (wb_val)
);

// File: tb/test_oaddr_unit.sv
module test_oaddr_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start, acc_done, wr_en;
  logic [2:0]  mode, sel, wr_idx;
  logic [15:0] disp, pc_addr, wr_data;
  logic [1:0]  opsize;
  logic [3:0]  pc_ofs;
  logic [127:0] gpr_flat;
  logic [7:0]  bank_dat, bank_add, bank_stk, bank_prg;
  logic        ea_vld, ea_err, wb_en;
  logic [23:0] ea;
  logic [2:0]  wb_idx;
  logic [15:0] wb_val;

  logic [15:0] g [8];
  int checks = 0;
  int errors = 0;
  bit flip = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always_comb for (int i = 0; i < 8; i++) gpr_flat[i*16 +: 16] = g[i];

  oaddr_unit i_oaddr_unit (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .sel(sel),
    .disp(disp), .opsize(opsize), .pc_addr(pc_addr), .pc_ofs(pc_ofs),
    .gpr_flat(gpr_flat), .bank_dat(bank_dat), .bank_add(bank_add),
    .bank_stk(bank_stk), .bank_prg(bank_prg), .acc_done(acc_done),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .ea_vld(ea_vld),
    .ea(ea), .ea_err(ea_err), .wb_en(wb_en), .wb_idx(wb_idx), .wb_val(wb_val)
  );

  task automatic chk(bit ok, string rq, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  function automatic logic [7:0] bank_of(int s);
    case (s % 4)
      2:       return bank_add;
      3:       return bank_stk;
      default: return bank_dat;
    endcase
  endfunction

  // {err, address}
  function automatic logic [24:0] exp_ea(int m, int s, logic [15:0] d, int sz);
    logic [15:0] lo;
    case (m)
      0: if (s > 3) return {1'b1, 24'h0};
         else return {1'b0, bank_of(s), g[s]};
      1: if (s > 3 || sz == 3) return {1'b1, 24'h0};
         else return {1'b0, bank_of(s), g[s]};
      2: begin
        lo = g[s] + {{8{d[7]}}, d[7:0]};
        return {1'b0, bank_of(s), lo};
      end
      3: if (s > 3) return {1'b1, 24'h0};
         else begin lo = g[s] + d; return {1'b0, bank_of(s), lo}; end
      4: if (s > 1) return {1'b1, 24'h0};
         else begin lo = g[s] + g[7]; return {1'b0, bank_dat, lo}; end
      5: begin
        lo = pc_addr + 16'(pc_ofs) + d;
        return {1'b0, bank_prg, lo};
      end
      default: return {1'b1, 24'h0};
    endcase
  endfunction

  function automatic string tag_of(int m, bit err);
    if (err) return (m == 3) ? "R7" : (m == 4) ? "R8" : "R11";
    case (m)
      0: return "R2";
      1: return "R3";
      2: return "R6";
      3: return "R7";
      4: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic issue(int m, int s, logic [15:0] d, int sz);
    @(negedge clk);
    mode = 3'(m); sel = 3'(s); disp = d; opsize = 2'(sz); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run_op(int m, int s, logic [15:0] d, int sz, string extra);
    logic [24:0] e;
    logic [15:0] oldp, step, expw;
    bit          pinc_ok;
    string       tg;
    e       = exp_ea(m, s, d, sz);
    tg      = (extra != "") ? extra : tag_of(m, e[24]);
    pinc_ok = (m == 1) && !e[24];
    oldp    = g[s];
    step    = 16'(1 << sz);
    issue(m, s, d, sz);
    chk(ea_vld == 1'b1, "R12 valid pulse", 32'(ea_vld), 1);
    chk(ea_err == e[24], tg, 32'(ea_err), 32'(e[24]));
    chk(ea == e[23:0], tg, 32'(ea), 32'(e[23:0]));
    if (m <= 3 && !e[24])
      chk(ea[23:16] == bank_of(s), "R1 bank byte", 32'(ea[23:16]), 32'(bank_of(s)));
    if (m == 1) begin
      flip = !flip;
      acc_done = 1'b1;
      wr_en    = 1'b1;
      wr_idx   = flip ? 3'(s) : 3'((s + 1) % 8);
      wr_data  = 16'hA500 ^ 16'(s * 16'h0111);
      #1;
      chk(wb_en == pinc_ok, "R3 writeback enable", 32'(wb_en), 32'(pinc_ok));
      expw = (flip && pinc_ok) ? wr_data : 16'(oldp + step);
      if (pinc_ok) begin
        chk(wb_idx == 3'(s), "R3 writeback index", 32'(wb_idx), 32'(s));
        chk(wb_val == expw, flip ? "R4 write data wins" : "R3 step",
            32'(wb_val), 32'(expw));
      end
      @(posedge clk);
      #1;
      g[wr_idx] = wr_data;
      if (pinc_ok) g[s] = expw;
      @(negedge clk);
      acc_done = 1'b0;
      wr_en    = 1'b0;
      if (pinc_ok) begin
        issue(0, s, 16'h0, 1);
        chk(ea[15:0] == expw, "R5 later use sees new value", 32'(ea[15:0]), 32'(expw));
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R12 actual=%0d expected=%0d", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] dl [4];
    dl = '{16'h0000, 16'h007F, 16'hFF80, 16'h8123};
    rst_n = 1'b0; start = 1'b0; acc_done = 1'b0; wr_en = 1'b0;
    mode = '0; sel = '0; disp = '0; opsize = '0; wr_idx = '0; wr_data = '0;
    pc_addr = 16'hFFFE; pc_ofs = 4'd4;
    bank_dat = 8'h11; bank_add = 8'h22; bank_stk = 8'h33; bank_prg = 8'h44;
    g = '{16'h7FFF, 16'h1234, 16'h8000, 16'hFFFF, 16'h00F0, 16'hFF00, 16'h4000, 16'h8001};
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk({ea_vld, ea_err, wb_en} == 3'b000 && ea == 24'h0, "R12 reset state",
        32'({ea_vld, ea_err, wb_en}), 0);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R3: completion with nothing pending writes nothing
    @(negedge clk);
    acc_done = 1'b1; #1;
    chk(wb_en == 1'b0, "R3 idle completion", 32'(wb_en), 0);
    @(negedge clk);
    acc_done = 1'b0;

    // sweep every mode, selector and displacement
    for (int m = 0; m < 8; m++)
      for (int s = 0; s < 8; s++)
        for (int k = 0; k < 4; k++)
          if (m == 1)
            for (int sz = 0; sz < 4; sz++) run_op(m, s, dl[k], sz, "");
          else
            run_op(m, s, dl[k], 1, "");

    // R12: address holds between starts
    issue(2, 5, 16'h0003, 1);
    @(negedge clk);
    chk(ea_vld == 1'b0, "R12 valid is a pulse", 32'(ea_vld), 0);
    chk(ea == {bank_dat, 16'(g[5] + 16'h0003)}, "R12 hold", 32'(ea),
        32'({bank_dat, 16'(g[5] + 16'h0003)}));

    // R10: wrap without carry into the bank byte
    g[0] = 16'hFFFF; g[7] = 16'h0002;
    run_op(4, 0, 16'h0000, 1, "R10 base-index wrap");
    g[3] = 16'hFFFE;
    run_op(1, 3, 16'h0000, 2, "R10 post-increment wrap");
    pc_addr = 16'hFFF0;
    run_op(5, 6, 16'h000F, 1, "R10 pc-relative wrap");
    g[6] = 16'h0001;
    run_op(2, 6, 16'h00FE, 1, "R10 negative byte displacement");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule